// File: doc/BRIEF.md
# Power-Managed Mode Controller

This block tracks whether a small processor core is running, idling or fully asleep, and turns that state into clock and oscillator enables. A sleep strobe from the instruction path moves the core out of run mode. The idle-enable input, sampled with that strobe, chooses between idle, where only the CPU clock stops, and full sleep, where the peripheral clock and the primary oscillator stop as well. A two-bit clock-source select picks the internal oscillator (code 00) or the primary oscillator (any non-zero code). A start-up counter reports when the primary oscillator may be trusted.

The controller leaves idle or sleep on an enabled interrupt or on a watchdog time-out. Each wake raises exactly one one-cycle strobe. The vector strobe means "branch to the interrupt vector" and the resume strobe means "continue in line". A watchdog time-out while running asks for a watchdog reset instead. The asynchronous reset always returns the block to run mode on the internal oscillator, whatever mode it was in.

Top module: `pm_mode_ctrl`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, cpu_clk_en_o=1, per_clk_en_o=1, csel_o=00, int_osc_en_o=1, pri_osc_en_o=0, osc_stable_o=0, and wake_vec_o, wake_resume_o and wdt_rst_o are all 0.
- R2: In run mode, a sleep_i strobe with idle_en_i=1 and wdt_to_i=0 gives cpu_clk_en_o=0 and per_clk_en_o=1 from the next cycle on.
- R3: In run mode, a sleep_i strobe with idle_en_i=0 and wdt_to_i=0 gives cpu_clk_en_o=0, per_clk_en_o=0 and pri_osc_en_o=0 from the next cycle on.
- R4: In run mode, csel_o takes the value of csel_i one cycle later. Outside sleep, pri_osc_en_o=1 exactly when csel_o is non-zero. The internal oscillator is enabled whenever csel_o=00 outside sleep.
- R5: osc_stable_o goes high OST_CYCLES cycles after pri_osc_en_o goes high. It is 0 in every cycle where pri_osc_en_o is 0, and so it drops when the internal oscillator is selected.
- R6: In sleep, int_osc_en_o equals wdt_en_i OR fscm_en_i. Outside sleep, int_osc_en_o is also 1 whenever either of those inputs is 1.
- R7: In idle or sleep, a source i with irq_en_i[i]=1 and irq_flag_i[i]=1 returns the block to run mode in the next cycle (cpu_clk_en_o=1). A flag whose enable bit is 0 has no effect.
- R8: On an interrupt wake, wake_vec_o pulses for one cycle if gie_i=1. Otherwise wake_resume_o pulses for one cycle. The two strobes never assert together.
- R9: In idle or sleep, wdt_to_i=1 wakes the block with a wake_resume_o pulse, and an interrupt in the same cycle takes priority. In run mode, wdt_to_i=1 gives a one-cycle wdt_rst_o pulse, the mode stays run, and a sleep strobe in that cycle is ignored.
- R10: A wake leaves csel_o unchanged. csel_i changes during idle or sleep are ignored until run mode resumes.
- R11: sleep_i strobes that arrive in idle or sleep leave the mode unchanged.
- R12: Asserting rst_ni low from idle or sleep returns the block at once to run mode with csel_o=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Sleep-instruction strobe |
| idle_en_i | input | 1 | Idle selected on sleep strobe |
| csel_i | input | 2 | Clock-source select, 00 = internal oscillator |
| irq_en_i | input | N_IRQ | Per-source interrupt enables |
| irq_flag_i | input | N_IRQ | Per-source interrupt flags |
| gie_i | input | 1 | Global interrupt enable |
| wdt_to_i | input | 1 | Watchdog time-out pulse |
| wdt_en_i | input | 1 | Watchdog enabled |
| fscm_en_i | input | 1 | Fail-safe clock monitor enabled |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| pri_osc_en_o | output | 1 | Primary oscillator enable |
| int_osc_en_o | output | 1 | Internal oscillator enable |
| osc_stable_o | output | 1 | Primary oscillator start-up complete |
| csel_o | output | 2 | Effective clock-source select |
| wake_vec_o | output | 1 | Wake with branch to vector |
| wake_resume_o | output | 1 | Wake with in-line resume |
| wdt_rst_o | output | 1 | Watchdog reset request |

## Verification
The bench builds the controller with N_IRQ=4 and OST_CYCLES=5. The short start-up count lets the stable flag rise and fall several times in a few hundred cycles, including across sleep entry and across source switches. Four sources are enough to show a set flag with a cleared enable bit being ignored while a neighbouring enabled source wakes the block. With a narrow vector, the random phase hits interrupt and watchdog coincidences often.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int CSEL_W = 2;
  localparam logic [CSEL_W-1:0] CSEL_INTOSC = '0;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_SLEEP = 2'd2
  } pm_mode_e;

  typedef enum logic [1:0] {
    WAKE_NONE   = 2'd0,
    WAKE_VEC    = 2'd1,
    WAKE_RESUME = 2'd2
  } wake_act_e;
endpackage

// File: rtl/pm_wake_detect.sv
module pm_wake_detect #(
  parameter int N_IRQ = 8
) (
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_IRQ-1:0] irq_flag_i,
  input  logic             gie_i,
  input  logic             wdt_to_i,
  output pm_pkg::wake_act_e act_o
);
  import pm_pkg::*;

  logic [N_IRQ-1:0] hit;
  logic             irq_wake;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_src
    assign hit[i] = irq_en_i[i] & irq_flag_i[i];
  end

  assign irq_wake = |hit;

  // interrupt outranks watchdog
  always_comb begin
    if (irq_wake)      act_o = gie_i ? WAKE_VEC : WAKE_RESUME;
    else if (wdt_to_i) act_o = WAKE_RESUME;
    else               act_o = WAKE_NONE;
  end
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sleep_i,
  input  logic                      idle_en_i,
  input  logic                      wdt_to_i,
  input  logic [pm_pkg::CSEL_W-1:0] csel_i,
  input  pm_pkg::wake_act_e         act_i,
  output pm_pkg::pm_mode_e          mode_o,
  output logic [pm_pkg::CSEL_W-1:0] csel_o,
  output logic                      vec_o,
  output logic                      resume_o,
  output logic                      wdt_rst_o
);
  import pm_pkg::*;

  pm_mode_e          mode_q;
  logic [CSEL_W-1:0] csel_q;
  logic              vec_q, resume_q, wdt_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= PM_RUN;
      csel_q    <= CSEL_INTOSC;
      vec_q     <= 1'b0;
      resume_q  <= 1'b0;
      wdt_rst_q <= 1'b0;
    end else begin
      vec_q     <= 1'b0;
      resume_q  <= 1'b0;
      wdt_rst_q <= 1'b0;
      if (mode_q == PM_RUN) begin
        csel_q <= csel_i;
        if (wdt_to_i) wdt_rst_q <= 1'b1;
        else if (sleep_i) mode_q <= idle_en_i ? PM_IDLE : PM_SLEEP;
      end else if (act_i != WAKE_NONE) begin
        mode_q   <= PM_RUN;
        vec_q    <= (act_i == WAKE_VEC);
        resume_q <= (act_i == WAKE_RESUME);
      end
    end
  end

  assign mode_o    = mode_q;
  assign csel_o    = csel_q;
  assign vec_o     = vec_q;
  assign resume_o  = resume_q;
  assign wdt_rst_o = wdt_rst_q;

  AST_IDLE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PM_RUN && sleep_i && !wdt_to_i && idle_en_i) |=> (mode_q == PM_IDLE)); // R2
  AST_SLEEP_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PM_RUN && sleep_i && !wdt_to_i && !idle_en_i) |=> (mode_q == PM_SLEEP)); // R3
  AST_WAKE_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != PM_RUN && act_i != WAKE_NONE) |=> (mode_q == PM_RUN)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vec_q && resume_q)); // R8
  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_q || resume_q) |=> !(vec_q || resume_q)); // R8
  AST_WDT_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PM_RUN && wdt_to_i) |=> (wdt_rst_q && mode_q == PM_RUN)); // R9
  AST_CSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != PM_RUN) |=> $stable(csel_q)); // R10
  AST_IGNORE_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != PM_RUN && act_i == WAKE_NONE) |=> $stable(mode_q)); // R11
endmodule

// File: rtl/pm_osc_ctrl.sv
module pm_osc_ctrl #(
  parameter int OST_CYCLES = 1024
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  pm_pkg::pm_mode_e          mode_i,
  input  logic [pm_pkg::CSEL_W-1:0] csel_i,
  input  logic                      wdt_en_i,
  input  logic                      fscm_en_i,
  output logic                      pri_osc_en_o,
  output logic                      int_osc_en_o,
  output logic                      osc_stable_o
);
  import pm_pkg::*;

  localparam int CNT_W = (OST_CYCLES < 2) ? 1 : $clog2(OST_CYCLES);

  logic awake;
  logic stable_q;

  assign awake        = (mode_i != PM_SLEEP);
  assign pri_osc_en_o = awake && (csel_i != CSEL_INTOSC);
  // monitors keep the internal source alive in any mode
  assign int_osc_en_o = (awake && (csel_i == CSEL_INTOSC)) || wdt_en_i || fscm_en_i;
  assign osc_stable_o = stable_q && pri_osc_en_o;

  if (OST_CYCLES == 0) begin : g_no_ost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stable_q <= 1'b0;
      else         stable_q <= pri_osc_en_o;
    end
  end else begin : g_ost
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q    <= '0;
        stable_q <= 1'b0;
      end else if (!pri_osc_en_o) begin
        cnt_q    <= '0;
        stable_q <= 1'b0;
      end else if (!stable_q) begin
        if (cnt_q == CNT_W'(OST_CYCLES - 1)) stable_q <= 1'b1;
        else                                 cnt_q    <= cnt_q + 1'b1;
      end
    end
  end

  AST_STABLE_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pri_osc_en_o) |-> !osc_stable_o); // R5
  AST_SOURCE_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awake |-> (pri_osc_en_o || int_osc_en_o)); // R4
endmodule

// File: rtl/pm_mode_ctrl.sv
module pm_mode_ctrl #(
  parameter int N_IRQ      = 8,
  parameter int OST_CYCLES = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic             idle_en_i,
  input  logic [1:0]       csel_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_IRQ-1:0] irq_flag_i,
  input  logic             gie_i,
  input  logic             wdt_to_i,
  input  logic             wdt_en_i,
  input  logic             fscm_en_i,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             pri_osc_en_o,
  output logic             int_osc_en_o,
  output logic             osc_stable_o,
  output logic [1:0]       csel_o,
  output logic             wake_vec_o,
  output logic             wake_resume_o,
  output logic             wdt_rst_o
);
  import pm_pkg::*;

  wake_act_e         act;
  pm_mode_e          mode;
  logic [CSEL_W-1:0] csel;

  pm_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
    .irq_en_i  (irq_en_i),
    .irq_flag_i(irq_flag_i),
    .gie_i     (gie_i),
    .wdt_to_i  (wdt_to_i),
    .act_o     (act)
  );

  pm_mode_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sleep_i  (sleep_i),
    .idle_en_i(idle_en_i),
    .wdt_to_i (wdt_to_i),
    .csel_i   (csel_i),
    .act_i    (act),
    .mode_o   (mode),
    .csel_o   (csel),
    .vec_o    (wake_vec_o),
    .resume_o (wake_resume_o),
    .wdt_rst_o(wdt_rst_o)
  );

  pm_osc_ctrl #(.OST_CYCLES(OST_CYCLES)) u_osc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .csel_i      (csel),
    .wdt_en_i    (wdt_en_i),
    .fscm_en_i   (fscm_en_i),
    .pri_osc_en_o(pri_osc_en_o),
    .int_osc_en_o(int_osc_en_o),
    .osc_stable_o(osc_stable_o)
  );

  assign cpu_clk_en_o = (mode == PM_RUN);
  assign per_clk_en_o = (mode != PM_SLEEP);
  assign csel_o       = csel;

  AST_CPU_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_clk_en_o && !wdt_to_i && !(|(irq_en_i & irq_flag_i))) |=> !cpu_clk_en_o); // R11
endmodule

// File: tb/tb_pm_mode_ctrl.sv
`timescale 1ns/100ps
module tb_pm_mode_ctrl;
  localparam int N  = 4;
  localparam int OST = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep = 0, idle_en = 0, gie = 0, wdt_to = 0, wdt_en = 0, fscm_en = 0;
  logic [1:0] csel = 2'b00;
  logic [N-1:0] irq_en = '0, irq_flag = '0;
  logic cpu_o, per_o, pri_o, into_o, stab_o, vec_o, res_o, wrst_o;
  logic [1:0] csel_o;

  always #2.5 clk = ~clk;

  pm_mode_ctrl #(.N_IRQ(N), .OST_CYCLES(OST)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_i(sleep), .idle_en_i(idle_en),
    .csel_i(csel), .irq_en_i(irq_en), .irq_flag_i(irq_flag), .gie_i(gie),
    .wdt_to_i(wdt_to), .wdt_en_i(wdt_en), .fscm_en_i(fscm_en),
    .cpu_clk_en_o(cpu_o), .per_clk_en_o(per_o), .pri_osc_en_o(pri_o),
    .int_osc_en_o(into_o), .osc_stable_o(stab_o), .csel_o(csel_o),
    .wake_vec_o(vec_o), .wake_resume_o(res_o), .wdt_rst_o(wrst_o));

  // reference model state: mode 0 run, 1 idle, 2 sleep
  int m_mode, m_csel, m_cnt;
  bit m_stable, m_vec, m_res, m_wrst;
  int vectors = 0, miscompares = 0;
  bit done = 0;
  string req = "R1";

  task automatic model_reset();
    m_mode = 0; m_csel = 0; m_cnt = 0;
    m_stable = 0; m_vec = 0; m_res = 0; m_wrst = 0;
  endtask

  task automatic model_step();
    bit irqw, pri;
    int nm;
    irqw = (irq_en & irq_flag) != 0;
    pri  = (m_csel != 0) && (m_mode != 2);
    if (!pri) begin m_cnt = 0; m_stable = 0; end
    else if (!m_stable) begin
      if (m_cnt == OST - 1) m_stable = 1; else m_cnt++;
    end
    m_vec = 0; m_res = 0; m_wrst = 0; nm = m_mode;
    if (m_mode == 0) begin
      m_csel = int'(csel);
      if (wdt_to) m_wrst = 1;
      else if (sleep) nm = idle_en ? 1 : 2;
    end else if (irqw || wdt_to) begin
      nm = 0;
      m_vec = irqw && gie;
      m_res = !(irqw && gie);
    end
    m_mode = nm;
  endtask

  task automatic cmp(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit pri;
    pri = (m_csel != 0) && (m_mode != 2);
    cmp("cpu_clk_en", int'(cpu_o), int'(m_mode == 0));
    cmp("per_clk_en", int'(per_o), int'(m_mode != 2));
    cmp("pri_osc_en", int'(pri_o), int'(pri));
    cmp("int_osc_en", int'(into_o),
        int'(((m_csel == 0) && (m_mode != 2)) || wdt_en || fscm_en));
    cmp("osc_stable", int'(stab_o), int'(m_stable && pri));
    cmp("csel", int'(csel_o), m_csel);
    cmp("wake_vec", int'(vec_o), int'(m_vec));
    cmp("wake_resume", int'(res_o), int'(m_res));
    cmp("wdt_rst", int'(wrst_o), int'(m_wrst));
  endtask

  // one clock: model update at the edge, compare at the falling edge
  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      if (!rst_ni) model_reset(); else model_step();
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic pulse_sleep(bit idle);
    idle_en = idle; sleep = 1; step(); sleep = 0;
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    req = "R1"; compare_all(); step(3);
    rst_ni = 1; step(2);

    req = "R4"; csel = 2'b01; step(2);
    req = "R5"; step(OST + 2);
    req = "R4"; csel = 2'b00; step(3);

    req = "R2"; pulse_sleep(1); step(2);
    req = "R11"; pulse_sleep(1); pulse_sleep(0); step(1);
    req = "R7"; irq_flag = 4'b0100; step(3);
    req = "R8"; gie = 1; irq_en = 4'b0100; step(2);
    irq_flag = '0; irq_en = '0; step(2);

    req = "R5"; csel = 2'b01; step(OST + 2);
    req = "R3"; pulse_sleep(0); step(2);
    req = "R6"; fscm_en = 1; step(2); fscm_en = 0; wdt_en = 1; step(2); wdt_en = 0; step(1);
    req = "R10"; csel = 2'b10; step(3);
    req = "R9"; wdt_to = 1; step(); wdt_to = 0; step(OST + 3);

    req = "R8"; gie = 0; pulse_sleep(1);
    irq_en = 4'b0001; irq_flag = 4'b0001; step(); irq_flag = '0; step(2);

    req = "R9"; gie = 1; pulse_sleep(0);
    irq_flag = 4'b0001; wdt_to = 1; step(); irq_flag = '0; wdt_to = 0; step(2);
    wdt_to = 1; sleep = 1; step(); wdt_to = 0; sleep = 0; step(2);

    req = "R12"; csel = 2'b11; step(OST + 1); pulse_sleep(0); step(2);
    @(posedge clk); #1 rst_ni = 0; model_reset();
    @(negedge clk); compare_all(); step(2);
    rst_ni = 1; step(2);

    req = "R7";
    for (int c = 0; c < 600; c++) begin
      sleep    = ($urandom % 6) == 0;
      idle_en  = $urandom % 2;
      if (($urandom % 12) == 0) csel = 2'($urandom);
      irq_en   = N'($urandom);
      irq_flag = (($urandom % 5) == 0) ? N'($urandom) : '0;
      gie      = $urandom % 2;
      wdt_to   = ($urandom % 20) == 0;
      wdt_en   = ($urandom % 8) == 0;
      fscm_en  = ($urandom % 9) == 0;
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL %s watchdog act=hung exp=done", req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule